// File: doc/BRIEF.md
# Preferred-Path Switch Output Port

This block is one output port of a mesh switch. The port stores one preferred input, which can be changed at run time. A flit that arrives on the preferred input reaches the output in the same cycle, with no arbitration. The routing check for that flit happens further downstream. Flits from every other input, and preferred flits that cannot pass straight through, are held in per-input FIFOs outside this block. When the output is free, a round-robin arbiter grants one FIFO per cycle. The granted flit goes to a one-entry output stage and leaves the port one cycle after its grant.

The port observes an almost-full flag from the next hop. While that flag is high, the port sends nothing and grants nothing. A preferred flit that arrives during that time is marked for enqueueing so that it is not lost. A configuration write is held as pending. It takes effect at the first clock edge on which the old preferred input is carrying no flit, so a flit is never split between two paths.

Top module: `ppx_output_port`

## Requirements
- R1: After reset, `pref_sel` equals parameter RESET_PREF (default 0), `out_valid` is 0 when no flit is present, and no FIFO is popped.
- R2: When `in_valid[pref_sel]` is 1 and `ds_almost_full` is 0, `out_flit` carries that input's flit in the same cycle, `out_bypass` is 1, and that flit raises no `enq_req`.
- R3: An input is eligible for arbitration when its FIFO is non-empty, or when a flit arriving on it needs enqueueing. If an input is granted with an empty FIFO, its arriving flit moves straight into the output stage, with no pop and no `enq_req`.
- R4: The arbiter grants at most one input per cycle, searching from a pointer; after a grant to input i the pointer moves to i+1 modulo NUM_IN. A grant to a non-empty FIFO i raises `fifo_pop[i]` (bit i selects input i).
- R5: A granted flit appears on `out_flit` with `out_valid` 1 and `out_bypass` 0 in the cycle after its grant, unless that cycle is blocked.
- R6: If the preferred input has a flit while a granted flit is waiting in the output stage, the preferred flit is sent. The waiting flit stays in the stage, and no new grant is issued that cycle.
- R7: While `ds_almost_full` is 1, `out_valid` is 0 and `fifo_pop` is 0. A flit on the preferred input raises its `enq_req` bit and is not sent straight through.
- R8: A flit arriving on any input that is neither sent straight through nor granted directly raises `enq_req` for that input.
- R9: A write (`cfg_we` 1, `cfg_pref` value) becomes pending. The pending value moves to `pref_sel` at the first later clock edge where `in_valid[pref_sel]` is 0.
- R10: A write whose `cfg_pref` is NUM_IN or above is ignored, and `pref_sel` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_flit | input | NUM_IN*FLIT_W | Arriving flit per input; input i is at bits [i*FLIT_W +: FLIT_W] |
| in_valid | input | NUM_IN | Arriving flit is routed to this output, one bit per input |
| fifo_flit | input | NUM_IN*FLIT_W | Head entry of each input FIFO |
| fifo_nonempty | input | NUM_IN | FIFO holds at least one flit |
| cfg_we | input | 1 | Preferred-input write strobe |
| cfg_pref | input | $clog2(NUM_IN) | New preferred input index |
| ds_almost_full | input | 1 | Next hop cannot accept more flits |
| out_flit | output | FLIT_W | Flit driven onto the output link |
| out_valid | output | 1 | `out_flit` is valid |
| out_bypass | output | 1 | Current flit comes from the preferred path |
| fifo_pop | output | NUM_IN | Remove head of FIFO i |
| enq_req | output | NUM_IN | Arriving flit on input i must be written into its FIFO |
| pref_sel | output | $clog2(NUM_IN) | Preferred input now in force |

## Verification
The bench targets the collision between a preferred flit and a flit waiting in the output stage. A design that got this wrong would lose the staged flit, or would overwrite it with a new grant. Backpressure is applied while a preferred flit arrives; a faulty port would send that flit anyway or drop it instead of raising its enqueue request. Arbitration is checked when the pointer wraps, and when the only eligible input has an empty FIFO but a flit arriving. An error there would show up as a wrong pop, a double enqueue, or a missing flit one cycle later. Configuration is written while the old preferred input is busy, and an out-of-range index is written. A port that switched early, or accepted a bad index, would show the wrong `pref_sel` and send a flit from the wrong input.

// File: rtl/ppx_pkg.sv
// Shared constants and helpers for the preferred-path output port.
// Assumes NUM_IN >= 2 everywhere it is used.
package ppx_pkg;
    localparam int PPX_FLIT_W = 39;
    localparam int PPX_NUM_IN = 6;

    // Index following idx, wrapping at n.
    function automatic int unsigned ppx_wrap_inc(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/ppx_rr_arbiter.sv
// Round-robin arbiter: grants the first requester at or after the pointer,
// then moves the pointer past the winner. Grants only while en is high.
// Assumes req is stable during the cycle it is sampled.
module ppx_rr_arbiter #(
    parameter int N = 6,
    localparam int IW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] ptr_d;
    logic          hit;

    // Search from the pointer for the first request and compute the next pointer.
    always_comb begin
        grant = '0;
        hit   = 1'b0;
        ptr_d = ptr_q;
        for (int k = 0; k < N; k++) begin
            int unsigned idx;
            idx = int'(ptr_q) + k;
            if (idx >= N) idx = idx - N;
            if (en && !hit && req[idx]) begin
                hit        = 1'b1;
                grant[idx] = 1'b1;
                ptr_d      = IW'(ppx_pkg::ppx_wrap_inc(idx, N));
            end
        end
    end

    // Hold the priority pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/ppx_pref_cfg.sv
// Preferred-input register with staged update. A write is kept pending and
// copied into the active index only on a cycle where the old preferred input
// carries no flit. Out-of-range writes are dropped.
module ppx_pref_cfg #(
    parameter int N          = 6,
    parameter int RESET_PREF = 0,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [N-1:0]  busy,
    output logic [IW-1:0] cur
);
    logic [IW-1:0] pend_q;
    logic          pend_vld_q;
    logic          safe;

    // Old path is idle when its input carries no flit.
    always_comb safe = !busy[cur];

    // Capture legal writes and apply them at a safe point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur        <= IW'(RESET_PREF);
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
        end else begin
            if (pend_vld_q && safe) begin
                cur        <= pend_q;
                pend_vld_q <= 1'b0;
            end
            if (wr_en && (int'(wr_idx) < N)) begin
                pend_q     <= wr_idx;
                pend_vld_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ppx_out_stage.sv
// One-entry output register for arbitrated flits. Loads a flit on load,
// clears on drain; load and drain in one cycle replace the entry.
module ppx_out_stage #(
    parameter int W = 39
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         drain,
    output logic         vld,
    output logic [W-1:0] data
);
    // Track occupancy and contents of the stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            data <= '0;
        end else begin
            if (load) begin
                vld  <= 1'b1;
                data <= load_data;
            end else if (drain) begin
                vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ppx_output_port.sv
// Output port with a preferred pass-through path and an arbitrated registered
// path. Assumes input FIFOs live outside and follow fifo_pop / enq_req, and
// that ds_almost_full is already synchronous to clk.
module ppx_output_port #(
    parameter int NUM_IN     = ppx_pkg::PPX_NUM_IN,
    parameter int FLIT_W     = ppx_pkg::PPX_FLIT_W,
    parameter int RESET_PREF = 0,
    localparam int IW = $clog2(NUM_IN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IN*FLIT_W-1:0] in_flit,
    input  logic [NUM_IN-1:0]        in_valid,
    input  logic [NUM_IN*FLIT_W-1:0] fifo_flit,
    input  logic [NUM_IN-1:0]        fifo_nonempty,
    input  logic                     cfg_we,
    input  logic [IW-1:0]            cfg_pref,
    input  logic                     ds_almost_full,
    output logic [FLIT_W-1:0]        out_flit,
    output logic                     out_valid,
    output logic                     out_bypass,
    output logic [NUM_IN-1:0]        fifo_pop,
    output logic [NUM_IN-1:0]        enq_req,
    output logic [IW-1:0]            pref_sel
);
    logic              bypass_go;
    logic              stg_vld;
    logic [FLIT_W-1:0] stg_data;
    logic              stg_drain;
    logic              grant_en;
    logic [NUM_IN-1:0] pref_mask;
    logic [NUM_IN-1:0] arrive_enq;
    logic [NUM_IN-1:0] eligible;
    logic [NUM_IN-1:0] grant;
    logic [FLIT_W-1:0] grant_flit;

    ppx_pref_cfg #(.N(NUM_IN), .RESET_PREF(RESET_PREF)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_pref),
        .busy(in_valid), .cur(pref_sel)
    );

    // Decide pass-through, stage drain and whether a new grant may issue.
    always_comb begin
        bypass_go = in_valid[pref_sel] && !ds_almost_full;
        stg_drain = stg_vld && !bypass_go && !ds_almost_full;
        grant_en  = !ds_almost_full && (!stg_vld || stg_drain);
        pref_mask = NUM_IN'(1) << pref_sel;
    end

    // Arriving flits not sent straight through compete and may need enqueueing.
    always_comb begin
        arrive_enq = in_valid & ~(bypass_go ? pref_mask : '0);
        eligible   = fifo_nonempty | arrive_enq;
    end

    ppx_rr_arbiter #(.N(NUM_IN)) u_arb (
        .clk(clk), .rst_n(rst_n), .en(grant_en), .req(eligible), .grant(grant)
    );

    // Pick the granted flit: FIFO head if present, else the arriving flit.
    always_comb begin
        grant_flit = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (grant[i])
                grant_flit = fifo_nonempty[i] ? fifo_flit[i*FLIT_W +: FLIT_W]
                                              : in_flit[i*FLIT_W +: FLIT_W];
        end
    end

    ppx_out_stage #(.W(FLIT_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .load(|grant), .load_data(grant_flit),
        .drain(stg_drain), .vld(stg_vld), .data(stg_data)
    );

    // Drive FIFO controls and the output link.
    always_comb begin
        fifo_pop   = grant & fifo_nonempty;
        enq_req    = arrive_enq & ~(grant & ~fifo_nonempty);
        out_bypass = bypass_go;
        out_valid  = bypass_go || stg_drain;
        out_flit   = bypass_go ? in_flit[pref_sel*FLIT_W +: FLIT_W] : stg_data;
    end
endmodule

// File: rtl/ppx_output_port_chk.sv
// Property checker for ppx_output_port, attached by bind below.
module ppx_output_port_chk #(
    parameter int NUM_IN = 6,
    parameter int FLIT_W = 39,
    localparam int IW = $clog2(NUM_IN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_IN-1:0] in_valid,
    input logic [NUM_IN-1:0] fifo_nonempty,
    input logic              ds_almost_full,
    input logic              out_valid,
    input logic              out_bypass,
    input logic [NUM_IN-1:0] fifo_pop,
    input logic [NUM_IN-1:0] enq_req,
    input logic [IW-1:0]     pref_sel
);
    assert_pref_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[pref_sel] && !ds_almost_full) |-> (out_valid && out_bypass && !enq_req[pref_sel]));

    assert_pop_only_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop & ~fifo_nonempty) == '0);

    assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_pop));

    assert_granted_leaves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|fifo_pop) |=> (out_valid || ds_almost_full));

    assert_backpressure_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ds_almost_full |-> (!out_valid && fifo_pop == '0));

    assert_no_switch_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[pref_sel] |=> $stable(pref_sel));

    assert_pref_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pref_sel) < NUM_IN);
endmodule

bind ppx_output_port ppx_output_port_chk #(.NUM_IN(NUM_IN), .FLIT_W(FLIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fifo_nonempty(fifo_nonempty),
    .ds_almost_full(ds_almost_full), .out_valid(out_valid), .out_bypass(out_bypass),
    .fifo_pop(fifo_pop), .enq_req(enq_req), .pref_sel(pref_sel)
);

// File: tb/tb_ppx_output_port.sv
module tb_ppx_output_port;
    localparam int N  = 6;
    localparam int W  = 39;
    localparam int IW = $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N*W-1:0] in_flit, fifo_flit;
    logic [N-1:0]   in_valid, fifo_nonempty;
    logic           cfg_we;
    logic [IW-1:0]  cfg_pref;
    logic           ds_almost_full;
    logic [W-1:0]   out_flit;
    logic           out_valid, out_bypass;
    logic [N-1:0]   fifo_pop, enq_req;
    logic [IW-1:0]  pref_sel;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    ppx_output_port dut (
        .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .in_valid(in_valid),
        .fifo_flit(fifo_flit), .fifo_nonempty(fifo_nonempty), .cfg_we(cfg_we),
        .cfg_pref(cfg_pref), .ds_almost_full(ds_almost_full), .out_flit(out_flit),
        .out_valid(out_valid), .out_bypass(out_bypass), .fifo_pop(fifo_pop),
        .enq_req(enq_req), .pref_sel(pref_sel)
    );

    function automatic logic [W-1:0] arr_f(input int i);
        return {7'h41, 32'hA000_0000 + i};
    endfunction
    function automatic logic [W-1:0] head_f(input int i);
        return {7'h22, 32'hF000_0000 + i};
    endfunction

    // Vector: in_valid, nonempty, af, exp out_valid, exp bypass, exp source
    // (bit3 set = FIFO head, low bits = input), exp pop, exp enq. 31 bits.
    localparam int NV = 11;
    localparam logic [30:0] VEC [NV] = '{
        {6'b000001, 6'b000000, 1'b0, 1'b1, 1'b1, 4'h0, 6'b000000, 6'b000000},
        {6'b000000, 6'b000110, 1'b0, 1'b0, 1'b0, 4'h0, 6'b000010, 6'b000000},
        {6'b000000, 6'b000110, 1'b0, 1'b1, 1'b0, 4'h9, 6'b000100, 6'b000000},
        {6'b000001, 6'b000010, 1'b0, 1'b1, 1'b1, 4'h0, 6'b000000, 6'b000000},
        {6'b000000, 6'b000010, 1'b1, 1'b0, 1'b0, 4'h0, 6'b000000, 6'b000000},
        {6'b000011, 6'b000000, 1'b1, 1'b0, 1'b0, 4'h0, 6'b000000, 6'b000011},
        {6'b000000, 6'b000011, 1'b0, 1'b1, 1'b0, 4'hA, 6'b000001, 6'b000000},
        {6'b000100, 6'b000010, 1'b0, 1'b1, 1'b0, 4'h8, 6'b000010, 6'b000100},
        {6'b001000, 6'b000000, 1'b0, 1'b1, 1'b0, 4'h9, 6'b000000, 6'b000000},
        {6'b000000, 6'b000000, 1'b0, 1'b1, 1'b0, 4'h3, 6'b000000, 6'b000000},
        {6'b000000, 6'b000000, 1'b0, 1'b0, 1'b0, 4'h0, 6'b000000, 6'b000000}
    };
    localparam string VTAG [NV] = '{"R2", "R4", "R5", "R6", "R7", "R7", "R4", "R8", "R3", "R3", "R5"};

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            in_flit[i*W +: W]   = arr_f(i);
            fifo_flit[i*W +: W] = head_f(i);
        end
        rst_n = 1'b0; in_valid = '0; fifo_nonempty = '0;
        cfg_we = 1'b0; cfg_pref = '0; ds_almost_full = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "pref_sel", 64'(pref_sel), 64'd0);
        check("R1", "out_valid", 64'(out_valid), 64'd0);
        check("R1", "fifo_pop", 64'(fifo_pop), 64'd0);

        // Vector walk: each entry is applied for one cycle.
        for (int v = 0; v < NV; v++) begin
            logic [30:0] e;
            logic [W-1:0] xf;
            e = VEC[v];
            @(negedge clk);
            in_valid = e[30:25]; fifo_nonempty = e[24:19]; ds_almost_full = e[18];
            #1;
            check(VTAG[v], $sformatf("v%0d out_valid", v), 64'(out_valid), 64'(e[17]));
            check(VTAG[v], $sformatf("v%0d out_bypass", v), 64'(out_bypass), 64'(e[16]));
            check(VTAG[v], $sformatf("v%0d fifo_pop", v), 64'(fifo_pop), 64'(e[11:6]));
            check(VTAG[v], $sformatf("v%0d enq_req", v), 64'(enq_req), 64'(e[5:0]));
            if (e[17]) begin
                xf = e[15] ? head_f(int'(e[14:12])) : arr_f(int'(e[14:12]));
                check(VTAG[v], $sformatf("v%0d out_flit", v), 64'(out_flit), 64'(xf));
            end
        end

        // R9: write 4 while old preferred input 0 is busy; no switch yet.
        @(negedge clk);
        in_valid = 6'b000001; fifo_nonempty = '0; cfg_we = 1'b1; cfg_pref = 3'd4;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        #1 check("R9", "pref held while busy", 64'(pref_sel), 64'd0);
        in_valid = '0;
        @(negedge clk);
        #1 check("R9", "pref applied when idle", 64'(pref_sel), 64'd4);
        // R2: new preferred input passes straight through.
        in_valid = 6'b010000;
        #1;
        check("R2", "bypass from input 4", 64'(out_bypass), 64'd1);
        check("R2", "flit from input 4", 64'(out_flit), 64'(arr_f(4)));
        check("R8", "old preferred now enqueues", 64'(enq_req), 64'd0);
        @(negedge clk);
        in_valid = 6'b000001;
        #1 check("R8", "input 0 arrival enqueued or granted", 64'(out_bypass), 64'd0);
        @(negedge clk);
        in_valid = '0;

        // R10: out-of-range write is dropped.
        @(negedge clk);
        cfg_we = 1'b1; cfg_pref = 3'd7;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        #1 check("R10", "pref after index 7", 64'(pref_sel), 64'd4);

        // R9: legal write with idle input applies after two edges.
        @(negedge clk);
        cfg_we = 1'b1; cfg_pref = 3'd2;
        @(negedge clk);
        cfg_we = 1'b0;
        #1 check("R9", "pref still old after one edge", 64'(pref_sel), 64'd4);
        @(negedge clk);
        #1 check("R9", "pref switched to 2", 64'(pref_sel), 64'd2);

        finish_run();
    end
endmodule